// File: doc/BRIEF.md
# Three-Level Interrupt Summary Controller

This block collects up to 256 interrupt lines and reports them to a host processor through one active-high request output. Every line has its own trigger setup (rising edge, falling edge, both edges, high level or low level), its own pair of mask bits and a sticky pending flag. Pending flags are summarised in three levels: eight lines form a group, eight groups form a bank, and one root byte shows which banks hold anything pending. An interrupt service routine reads the root, then the bank byte it points to, then the pending byte of each flagged group. This finds the source in three reads without scanning all lines.

The host reaches the block over a byte-wide synchronous bus with an address, a write strobe and a read strobe. The registers sit at a fixed window starting at byte address 0x1BB. Per-line state is reached indirectly: the host first writes a group number into a selector register. After that, the trigger-setup, pending and live-pin registers all act on that group. A setup byte names the line it targets inside the group and carries its own commit flag. One write can therefore mask a line and discard its pending flag at the same time. The live-pin register lets software read the current logic level of eight lines at once.

Top module: `irq_tree_ctrl`

## Requirements
- R1: Register offsets from base 0x1BB are: 0 root summary, 1..4 bank summaries for banks 0..3, 5 group selector (reads back the value written), 6 pending flags of the selected group, 7 line setup (reads zero), 8 live pin levels of the selected group. Any other offset reads zero. Read data appears on `bus_rdata_o` at the clock edge that samples `bus_rd_i`, and it holds until the next read.
- R2: Line n belongs to group n/8 at bit n%8, and group g belongs to bank g/8 at bit g%8. A bank summary bit is the OR of the eight pending flags of its group.
- R3: In the root summary byte, bank i appears at bit i+1. Bit 0 always reads zero.
- R4: Setup byte fields are: bit0 level mode (0 means edge mode), bit1 masks falling edge or low level, bit2 masks rising edge or high level, bit3 clears the pending flag, bits 6:4 give the line inside the selected group, and bit7 is the commit flag. Bits 0 to 2 are stored only when bit7 is 1. Bit3 acts whether or not bit7 is set.
- R5: In edge mode, an unmasked rising edge and an unmasked falling edge each set the pending flag. The two edges may be enabled together.
- R6: In level mode, clearing bit2 selects active-high and clearing bit1 selects active-low. While the line stays active, the pending flag remains set even after a clear.
- R7: Pending flags fall only through a clear. If a detection and a clear reach the same line in the same cycle, the detection wins and the flag stays set.
- R8: Live pin levels pass through a two-flop synchroniser. A read issued in the cycle after a pin changes still returns the old level.
- R9: After reset every line has both mask bits set and is in edge mode. All pending flags are clear and `irq_o` is low.
- R10: `irq_o` is high exactly when some root bank bit is set.
- R11: When the selector holds 32 or more, the pending and live registers read zero and setup writes change no line.
- R12: A setup write with bits 3:1 all set, plus bit7, masks the line and clears its pending flag in one access. Later edges on that line are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 256 | Raw interrupt lines, asynchronous to clk |
| bus_addr_i | input | 9 | Byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Summary request to the host, active high |

## Verification
A line's detector and a host clear can act on the same pending flag in the same clock edge. The bench first latches a rising edge on a line and lets the line fall. It then raises the line again and times the clear write so that its strobe is sampled at the edge where the synchronised rise is detected, two edges after the pin moves. The pending byte read afterwards must still show the flag. A plain clear with no edge must then return zero. A level-mode line that stays active is also cleared while it is asserted, and it must read as pending again straight away.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int LPB = 8;

  localparam int CFG_LVL  = 0;
  localparam int CFG_MFE  = 1;
  localparam int CFG_MRE  = 2;
  localparam int CFG_CLR  = 3;
  localparam int CFG_IDX  = 4;
  localparam int CFG_WEN  = 7;

  localparam int OFS_ROOT = 0;
  localparam int OFS_MST0 = 1;
  localparam int OFS_SEL  = 5;
  localparam int OFS_STAT = 6;
  localparam int OFS_CFG  = 7;
  localparam int OFS_RT   = 8;

  function automatic int grp_of(int line);
    return line / LPB;
  endfunction

  function automatic int pos_of(int line);
    return line % LPB;
  endfunction

  // trigger decision for one line from its stored setup and synchronised samples
  function automatic logic trig_hit(logic lvl, logic mfe, logic mre,
                                    logic cur, logic prv);
    logic up, dn;
    up = cur & ~prv;
    dn = ~cur & prv;
    if (lvl) return (cur & ~mre) | (~cur & ~mfe);
    return (up & ~mre) | (dn & ~mfe);
  endfunction
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_tree_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_i,
  input  logic       set_we_i,
  input  logic       clr_i,
  input  logic [2:0] set_i,
  output logic       live_o,
  output logic       pend_o,
  output logic       hit_o
);
  logic s1_q, s2_q, prv_q;
  logic lvl_q, mfe_q, mre_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      prv_q <= 1'b0;
    end else begin
      s1_q  <= raw_i;
      s2_q  <= s1_q;
      prv_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      mfe_q <= 1'b1;
      mre_q <= 1'b1;
    end else if (set_we_i) begin
      lvl_q <= set_i[CFG_LVL];
      mfe_q <= set_i[CFG_MFE];
      mre_q <= set_i[CFG_MRE];
    end
  end

  assign hit_o = trig_hit(lvl_q, mfe_q, mre_q, s2_q, prv_q);

  // detection has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= hit_o | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
  assign live_o = s2_q;
endmodule

// File: rtl/irq_summary_tree.sv
module irq_summary_tree
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES = 256,
  localparam int NGRP = (NUM_LINES + LPB - 1) / LPB,
  localparam int NBNK = (NGRP + LPB - 1) / LPB
) (
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [NGRP-1:0]      grp_any_o,
  output logic [NBNK*LPB-1:0]  bnk_vec_o,
  output logic [NBNK-1:0]      bnk_any_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int HI = ((g + 1) * LPB > NUM_LINES) ? NUM_LINES - 1 : (g + 1) * LPB - 1;
    assign grp_any_o[g] = |pend_i[HI:g*LPB];
  end

  for (genvar k = 0; k < NBNK * LPB; k++) begin : g_pad
    if (k < NGRP) begin : g_real
      assign bnk_vec_o[k] = grp_any_o[k];
    end else begin : g_zero
      assign bnk_vec_o[k] = 1'b0;
    end
  end

  for (genvar b = 0; b < NBNK; b++) begin : g_bnk
    assign bnk_any_o[b] = |bnk_vec_o[b*LPB +: LPB];
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int ADDR_W = 9,
  parameter int BASE = 'h1BB,
  localparam int NGRP = (NUM_LINES + LPB - 1) / LPB,
  localparam int NBNK = (NGRP + LPB - 1) / LPB,
  localparam int PADL = NGRP * LPB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [7:0]           bus_wdata_i,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] live_i,
  input  logic [NBNK*LPB-1:0]  bnk_vec_i,
  input  logic [NBNK-1:0]      bnk_any_i,
  output logic [7:0]           bus_rdata_o,
  output logic                 set_write_o,
  output logic [7:0]           sel_o,
  output logic                 sel_ok_o
);
  logic [ADDR_W-1:0] ofs;
  logic [7:0]        sel_q, rdata_q, rd_mux, root_b, pend_b, live_b;
  logic [PADL-1:0]   pend_pad, live_pad;
  int                oi, si;

  assign ofs      = bus_addr_i - ADDR_W'(BASE);
  assign oi       = int'(ofs);
  assign si       = int'(sel_q);
  assign sel_ok_o = si < NGRP;
  assign sel_o    = sel_q;

  assign pend_pad = PADL'(pend_i);
  assign live_pad = PADL'(live_i);

  always_comb begin
    root_b = '0;
    for (int b = 0; b < NBNK; b++) root_b[b+1] = bnk_any_i[b];
  end

  always_comb begin
    pend_b = '0;
    live_b = '0;
    if (sel_ok_o) begin
      pend_b = pend_pad[si*LPB +: LPB];
      live_b = live_pad[si*LPB +: LPB];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (oi == OFS_ROOT)                                rd_mux = root_b;
    else if (oi >= OFS_MST0 && oi < OFS_MST0 + NBNK)   rd_mux = bnk_vec_i[(oi-OFS_MST0)*LPB +: LPB];
    else if (oi == OFS_SEL)                            rd_mux = sel_q;
    else if (oi == OFS_STAT)                           rd_mux = pend_b;
    else if (oi == OFS_RT)                             rd_mux = live_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr_i && oi == OFS_SEL) sel_q <= bus_wdata_i;
      if (bus_rd_i)                  rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign set_write_o = bus_wr_i && (oi == OFS_CFG) && sel_ok_o;
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int ADDR_W = 9,
  parameter int BASE = 'h1BB,
  localparam int NGRP = (NUM_LINES + LPB - 1) / LPB,
  localparam int NBNK = (NGRP + LPB - 1) / LPB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [7:0]           bus_wdata_i,
  output logic [7:0]           bus_rdata_o,
  output logic                 irq_o
);
  // named internal events for the checker
  logic [NUM_LINES-1:0] stat_vec, rt_vec, hit_vec, tgt_vec;
  logic [NGRP-1:0]      grp_any;
  logic [NBNK*LPB-1:0]  bnk_vec;
  logic [NBNK-1:0]      bnk_any;
  logic                 cfg_write, sel_ok;
  logic [7:0]           blk_sel;
  logic [2:0]           tgt_pos;

  assign tgt_pos = bus_wdata_i[CFG_IDX +: 3];

  irq_reg_port #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .BASE(BASE)) port_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i), .pend_i(stat_vec),
    .live_i(rt_vec), .bnk_vec_i(bnk_vec), .bnk_any_i(bnk_any),
    .bus_rdata_o(bus_rdata_o), .set_write_o(cfg_write), .sel_o(blk_sel),
    .sel_ok_o(sel_ok)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign tgt_vec[n] = cfg_write && (int'(blk_sel) == grp_of(n)) &&
                        (int'(tgt_pos) == pos_of(n));
    irq_line_cell cell_i (
      .clk(clk), .rst_n(rst_n), .raw_i(line_i[n]),
      .set_we_i(tgt_vec[n] & bus_wdata_i[CFG_WEN]),
      .clr_i(tgt_vec[n] & bus_wdata_i[CFG_CLR]),
      .set_i(bus_wdata_i[2:0]),
      .live_o(rt_vec[n]), .pend_o(stat_vec[n]), .hit_o(hit_vec[n])
    );
  end

  irq_summary_tree #(.NUM_LINES(NUM_LINES)) tree_i (
    .pend_i(stat_vec), .grp_any_o(grp_any), .bnk_vec_o(bnk_vec), .bnk_any_o(bnk_any)
  );

  assign irq_o = |bnk_any;
endmodule

// File: rtl/irq_tree_ctrl_chk.sv
module irq_tree_ctrl_chk #(
  parameter int NUM_LINES = 256,
  parameter int ADDR_W = 9,
  parameter int BASE = 'h1BB
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic                 bus_wr_i,
  input logic                 bus_rd_i,
  input logic [7:0]           bus_rdata_o,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] stat_vec,
  input logic                 cfg_write,
  input logic [7:0]           blk_sel
);
  localparam int NGRP = (NUM_LINES + 7) / 8;

  // R1: read data only moves on a read strobe
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));

  // R3: root bit 0 never reports a bank
  a_r3_root_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == ADDR_W'(BASE)) |=> !bus_rdata_o[0]);

  // R7: no pending flag falls without a setup write
  a_r7_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_write |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

  // R10: request output needs some pending flag underneath
  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|stat_vec));

  // R11: out-of-range selector blocks setup writes
  a_r11_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(BASE + 7) && int'(blk_sel) >= NGRP) |-> !cfg_write);
endmodule

bind irq_tree_ctrl irq_tree_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .BASE(BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
  .stat_vec(stat_vec), .cfg_write(cfg_write), .blk_sel(blk_sel)
);

// File: tb/irq_tree_ctrl_tb_top.sv
module irq_tree_ctrl_tb_top;
  localparam int NL = 256;
  localparam int AW = 9;
  localparam int BASE = 'h1BB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  irq_tree_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(int ofs, int d);
    @(negedge clk);
    addr = AW'(BASE + ofs); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic br(int ofs, output int d);
    @(negedge clk);
    addr = AW'(BASE + ofs); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = int'(rdata);
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  function automatic int setup(int pos, int flags);
    return 'h80 | (pos << 4) | flags;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R9: reset state
    chk("R9 irq after reset", int'(irq), 0);
    br(0, v); chk("R9 root after reset", v, 0);
    for (int m = 1; m <= 4; m++) begin
      br(m, v); chk("R9 bank after reset", v, 0);
    end
    lines[7:0] = 8'hFF; idle(4);
    br(6, v); chk("R9 lines masked at reset", v, 0);
    lines[7:0] = 8'h00; idle(4);
    br(6, v); chk("R9 lines masked after fall", v, 0);

    // R2 R3 R5 R10 R12: sweep every line with rising-edge setup
    for (int n = 0; n < NL; n++) begin
      int g, b, p;
      g = n / 8; b = g / 8; p = n % 8;
      bw(5, g);
      bw(7, setup(p, 'h02));
      lines[n] = 1'b1; idle(4);
      br(0, v);     chk("R3 root bit", v, 1 << (b + 1));
      br(1 + b, v); chk("R2 bank bit", v, 1 << (g % 8));
      br(6, v);     chk("R5 rising pending", v, 1 << p);
      chk("R10 irq high", int'(irq), 1);
      bw(7, setup(p, 'h0E));
      br(6, v);     chk("R12 mask-ack clears", v, 0);
      br(0, v);     chk("R3 root clear", v, 0);
      chk("R10 irq low", int'(irq), 0);
      lines[n] = 1'b0;
      if (n % 17 == 0) begin
        idle(4);
        lines[n] = 1'b1; idle(4);
        br(6, v); chk("R12 masked edge ignored", v, 0);
        lines[n] = 1'b0; idle(4);
      end
    end

    // R5: falling edge only, then both edges, line 37 (group 4 bit 5)
    bw(5, 4);
    bw(7, setup(5, 'h04));
    lines[37] = 1'b1; idle(4);
    br(6, v); chk("R5 rise masked", v, 0);
    lines[37] = 1'b0; idle(4);
    br(6, v); chk("R5 falling pending", v, 'h20);
    bw(7, setup(5, 'h08));
    br(6, v); chk("R5 cleared", v, 0);
    lines[37] = 1'b1; idle(4);
    br(6, v); chk("R5 both edges rise", v, 'h20);
    bw(7, 'h58);
    br(6, v); chk("R4 clear without commit", v, 0);
    lines[37] = 1'b0; idle(4);
    br(6, v); chk("R5 both edges fall", v, 'h20);
    bw(7, setup(5, 'h0E));

    // R4: no commit bit, setup not stored
    bw(7, 'h50);
    lines[37] = 1'b1; idle(4);
    br(6, v); chk("R4 uncommitted setup", v, 0);
    lines[37] = 1'b0; idle(4);

    // R6: level modes, line 100 (group 12 bank 1 bit 4)
    bw(5, 12);
    bw(7, setup(4, 'h03));
    lines[100] = 1'b1; idle(4);
    br(6, v); chk("R6 high level pending", v, 'h10);
    br(0, v); chk("R3 root bank1", v, 'h04);
    bw(7, 'h48);
    br(6, v); chk("R6 relatch while active", v, 'h10);
    lines[100] = 1'b0; idle(4);
    bw(7, 'h48);
    br(6, v); chk("R6 clear once inactive", v, 0);
    bw(7, setup(4, 'h05));
    idle(2);
    br(6, v); chk("R6 low level pending", v, 'h10);
    lines[100] = 1'b1; idle(4);
    bw(7, 'h48);
    br(6, v); chk("R6 low clear when high", v, 0);
    bw(7, setup(4, 'h0E));
    lines[100] = 1'b0; idle(4);

    // R11: selector out of range
    bw(5, 32);
    br(5, v); chk("R1 selector readback", v, 32);
    br(6, v); chk("R11 pending reads zero", v, 0);
    br(8, v); chk("R11 live reads zero", v, 0);
    bw(7, setup(0, 'h00));
    bw(5, 0);
    lines[0] = 1'b1; idle(4);
    br(6, v); chk("R11 write ignored", v, 0);
    lines[0] = 1'b0; idle(4);
    br(9, v); chk("R1 unused offset", v, 0);
    br(7, v); chk("R1 setup reads zero", v, 0);

    // R8: live pin levels with two-flop latency, group 5
    bw(5, 5);
    begin
      int pats[4] = '{'hA5, 'h3C, 'hFF, 'h00};
      int prev;
      prev = 0;
      foreach (pats[i]) begin
        lines[40 +: 8] = 8'(pats[i]);
        br(8, v); chk("R8 old level", v, prev);
        idle(2);
        br(8, v); chk("R8 live level", v, pats[i]);
        prev = pats[i];
      end
    end

    // R7: detection and clear in the same cycle, line 200 (group 25 bank 3)
    bw(5, 25);
    bw(7, setup(0, 'h02));
    lines[200] = 1'b1; idle(4);
    br(6, v); chk("R7 first edge", v, 1);
    br(0, v); chk("R3 root bank3", v, 'h10);
    lines[200] = 1'b0; idle(4);
    lines[200] = 1'b1;
    idle(1);
    bw(7, 'h08);
    br(6, v); chk("R7 detect beats clear", v, 1);
    bw(7, 'h08);
    br(6, v); chk("R7 plain clear", v, 0);
    chk("R10 irq idle", int'(irq), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule